// File: doc/BRIEF.md
# ULPI Link Register Access Controller

This block is the link-side engine that reads and writes transceiver registers over an 8-bit ULPI bus. Each operation is a single request on a small request port: a direction flag, a register address and a write byte. The block answers with a one-cycle completion pulse, plus the returned byte for reads. On the bus it builds the command byte and sends any further bytes one at a time. Each byte is held until the transceiver accepts it with NXT. After a write it sends a one-cycle stop. For a read it releases the bus and takes the returned byte after the turnaround cycle.

Addresses up to 0x2E go out in the short form, where the command byte carries the address. Higher addresses use the long form: the command byte carries the escape code 0x2F and a separate address byte follows. The transceiver can take the bus at any time by raising DIR. The block then stops driving, waits for DIR to fall and for a turnaround cycle, and restarts the whole operation from the command byte. It keeps doing this until the operation completes, so the requester never sees an abort.

Top module: `ulpi_reg_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is idle: req_ready is 1, ulpi_data_oe, ulpi_stp and done are 0.
- R2: A write sends the command byte {2'b10, addr[5:0]} (or {2'b10, 6'h2F} in long form) and then the write byte. Each byte stays on ulpi_data_o with ulpi_data_oe high until a cycle with ulpi_nxt high. The next cycle drives ulpi_stp high for exactly one cycle with data 8'h00. done pulses in the cycle after that.
- R3: A read sends the command byte {2'b11, addr[5:0]} (or {2'b11, 6'h2F} in long form) and releases the bus once the last byte is accepted. The first cycle with DIR high is a turnaround cycle and is not sampled. The byte on ulpi_data_i in the next cycle with DIR high and NXT low is captured. done pulses one cycle later, with rdata holding that byte.
- R4: An address above 8'h2E selects the long form: the command byte carries 6'h2F and the full address byte follows it, also held until NXT. Addresses 8'h00 to 8'h2E use the short form with no address byte.
- R5: The block never drives ulpi_data_o (ulpi_data_oe low) while ulpi_dir is high, nor in the cycle in which ulpi_dir changes level.
- R6: If ulpi_dir rises while a command, address, write data or stop cycle is on the bus, ulpi_data_oe and ulpi_stp drop in that same cycle and no done is given. After DIR falls and one turnaround cycle passes, the operation restarts from the command byte and completes normally.
- R7: During a read, the operation is retried from the command byte if NXT is high in the data cycle (the transceiver is sending something else) or if DIR falls before any data cycle. No done is given for the abandoned attempt.
- R8: req_ready is low from the cycle after a request is accepted until the operation completes. Requests presented while busy are ignored. Each accepted request yields exactly one single-cycle done.
- R9: NXT is ignored in a turnaround cycle. A NXT seen while DIR falls does not count as acceptance of the restarted command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block idle, request will be taken |
| done | output | 1 | One-cycle pulse when an operation has completed |
| rdata | output | 8 | Byte returned by the last read |
| ulpi_dir | input | 1 | Bus direction from the transceiver, high = transceiver drives |
| ulpi_nxt | input | 1 | Transceiver accepts the byte / flow control |
| ulpi_stp | output | 1 | Stop strobe ending a write |
| ulpi_data_i | input | 8 | Sampled bus data |
| ulpi_data_o | output | 8 | Bus data driven by the link |
| ulpi_data_oe | output | 1 | Output enable for ulpi_data_o |

## Verification
Every one of the 256 addresses is written and then read back. Each run uses a different NXT latency, so the short and long forms and the 0x2E/0x2F boundary are each covered with held bytes. Aborts are injected at a different point from one operation to the next: on the command byte, on the address byte, on the write data, on the stop cycle, with NXT high in the read data cycle, and with DIR falling before the read data. Each injection shows that the retry restarts from the command byte rather than resuming. NXT is raised during turnaround cycles and stray requests are held during busy periods, which separates a correct turnaround and busy handling from one that counts those cycles as progress.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD,
    S_XADDR,
    S_WDATA,
    S_STOP,
    S_RTURN,
    S_RDATA,
    S_REND,
    S_HOLD
  } lrc_state_e;

  // States in which the link owns the bus
  function automatic logic is_tx_state(lrc_state_e s);
    return (s == S_CMD) || (s == S_XADDR) || (s == S_WDATA) || (s == S_STOP);
  endfunction

endpackage

// File: rtl/ulpi_rst_sync.sv
module ulpi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ulpi_dir_mon.sv
module ulpi_dir_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic ulpi_dir,
  output logic bus_free
);

  logic dir_q;

  // Reset to "transceiver owned" so the first cycle is treated as turnaround
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b1;
    end else begin
      dir_q <= ulpi_dir;
    end
  end

  // Link may drive only when DIR is low now and was low last cycle
  assign bus_free = !ulpi_dir && !dir_q;

endmodule

// File: rtl/ulpi_cmd_fmt.sv
module ulpi_cmd_fmt
  import ulpi_reg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int unsigned IMM_LAST = 46,
  parameter logic [5:0]  EXT_CODE = 6'h2F
) (
  input  logic              op_write,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              use_ext,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] xaddr_byte
);

  localparam logic [ADDR_W-1:0] LAST_SHORT = ADDR_W'(IMM_LAST);

  logic [1:0] opcode;

  assign use_ext  = (op_addr > LAST_SHORT);
  assign opcode   = op_write ? OP_WRITE : OP_READ;
  assign cmd_byte = {opcode, (use_ext ? EXT_CODE : op_addr[5:0])};

  generate
    if (ADDR_W == BYTE_W) begin : g_full
      assign xaddr_byte = op_addr;
    end else begin : g_pad
      assign xaddr_byte = {{(BYTE_W-ADDR_W){1'b0}}, op_addr};
    end
  endgenerate

endmodule

// File: rtl/ulpi_reg_fsm.sv
module ulpi_reg_fsm
  import ulpi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic              bus_free,
  input  logic              use_ext,
  input  logic [BYTE_W-1:0] rx_byte,
  output lrc_state_e        state,
  output logic              op_write,
  output logic [ADDR_W-1:0] op_addr,
  output logic [BYTE_W-1:0] op_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [BYTE_W-1:0] rdata
);

  lrc_state_e state_d;
  logic       accept;
  logic       capture;
  logic       done_d;
  logic       step;

  // A byte counts as taken only when NXT is seen with the bus owned by the link
  assign step = bus_free && ulpi_nxt;

  always_comb begin
    state_d = state;
    accept  = 1'b0;
    capture = 1'b0;
    done_d  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = S_CMD;
        end
      end
      S_CMD: begin
        if (ulpi_dir)  state_d = S_HOLD;
        else if (step) state_d = use_ext ? S_XADDR : (op_write ? S_WDATA : S_RTURN);
      end
      S_XADDR: begin
        if (ulpi_dir)  state_d = S_HOLD;
        else if (step) state_d = op_write ? S_WDATA : S_RTURN;
      end
      S_WDATA: begin
        if (ulpi_dir)  state_d = S_HOLD;
        else if (step) state_d = S_STOP;
      end
      S_STOP: begin
        if (ulpi_dir) begin
          state_d = S_HOLD;
        end else begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      S_RTURN: begin
        if (ulpi_dir) state_d = S_RDATA;
      end
      S_RDATA: begin
        if (!ulpi_dir) begin
          state_d = S_CMD;
        end else if (ulpi_nxt) begin
          state_d = S_HOLD;
        end else begin
          capture = 1'b1;
          done_d  = 1'b1;
          state_d = S_REND;
        end
      end
      S_REND: begin
        if (!ulpi_dir) state_d = S_IDLE;
      end
      S_HOLD: begin
        if (!ulpi_dir) state_d = S_CMD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_write <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else if (accept) begin
      op_write <= req_write;
      op_addr  <= req_addr;
      op_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (capture) begin
      rdata <= rx_byte;
    end
  end

  assign req_ready = (state == S_IDLE);

endmodule

// File: rtl/ulpi_reg_ctrl.sv
module ulpi_reg_ctrl
  import ulpi_reg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int unsigned IMM_LAST = 46,
  parameter logic [5:0]  EXT_CODE = 6'h2F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [7:0]        rdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  output logic              ulpi_stp,
  input  logic [7:0]        ulpi_data_i,
  output logic [7:0]        ulpi_data_o,
  output logic              ulpi_data_oe
);

  logic              rst_sync_n;
  logic              bus_free;
  lrc_state_e        state;
  logic              op_write;
  logic [ADDR_W-1:0] op_addr;
  logic [BYTE_W-1:0] op_wdata;
  logic              use_ext;
  logic [BYTE_W-1:0] cmd_byte;
  logic [BYTE_W-1:0] xaddr_byte;
  logic [BYTE_W-1:0] tx_byte;

  ulpi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ulpi_dir_mon u_dir (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ulpi_dir (ulpi_dir),
    .bus_free (bus_free)
  );

  ulpi_cmd_fmt #(
    .ADDR_W   (ADDR_W),
    .IMM_LAST (IMM_LAST),
    .EXT_CODE (EXT_CODE)
  ) u_fmt (
    .op_write   (op_write),
    .op_addr    (op_addr),
    .use_ext    (use_ext),
    .cmd_byte   (cmd_byte),
    .xaddr_byte (xaddr_byte)
  );

  ulpi_reg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ulpi_dir  (ulpi_dir),
    .ulpi_nxt  (ulpi_nxt),
    .bus_free  (bus_free),
    .use_ext   (use_ext),
    .rx_byte   (ulpi_data_i),
    .state     (state),
    .op_write  (op_write),
    .op_addr   (op_addr),
    .op_wdata  (op_wdata),
    .req_ready (req_ready),
    .done      (done),
    .rdata     (rdata)
  );

  always_comb begin
    unique case (state)
      S_CMD:   tx_byte = cmd_byte;
      S_XADDR: tx_byte = xaddr_byte;
      S_WDATA: tx_byte = op_wdata;
      default: tx_byte = '0;
    endcase
  end

  assign ulpi_data_oe = is_tx_state(state) && bus_free;
  assign ulpi_data_o  = ulpi_data_oe ? tx_byte : '0;
  assign ulpi_stp     = (state == S_STOP) && bus_free;

endmodule

// File: rtl/ulpi_reg_ctrl_chk.sv
module ulpi_reg_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       ulpi_dir,
  input logic       ulpi_nxt,
  input logic       ulpi_stp,
  input logic [7:0] ulpi_data_o,
  input logic       ulpi_data_oe
);

  AST_TURN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ulpi_dir) != ulpi_dir) |-> !ulpi_data_oe); // R5

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ulpi_data_oe && !ulpi_nxt) && ulpi_data_oe) |-> $stable(ulpi_data_o)); // R2

  AST_STP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> $past(ulpi_data_oe && ulpi_nxt)); // R2

  AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp); // R2

  AST_STP_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> (ulpi_data_o == 8'h00)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_ready && req_valid) |-> !req_ready); // R8

  AST_READ_DONE_AFTER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(ulpi_stp)) |-> $past(ulpi_dir)); // R3

endmodule

bind ulpi_reg_ctrl ulpi_reg_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .done         (done),
  .ulpi_dir     (ulpi_dir),
  .ulpi_nxt     (ulpi_nxt),
  .ulpi_stp     (ulpi_stp),
  .ulpi_data_o  (ulpi_data_o),
  .ulpi_data_oe (ulpi_data_oe)
);

// File: tb/ulpi_reg_ctrl_tb_top.sv
module ulpi_reg_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic       req_write;
  logic [7:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_ready;
  logic       done;
  logic [7:0] rdata;
  logic       dir;
  logic       nxt;
  logic       stp;
  logic [7:0] data_i;
  logic [7:0] data_o;
  logic       oe;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] phy_regs [256];

  always #5 clk = ~clk;

  ulpi_reg_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .done         (done),
    .rdata        (rdata),
    .ulpi_dir     (dir),
    .ulpi_nxt     (nxt),
    .ulpi_stp     (stp),
    .ulpi_data_i  (data_i),
    .ulpi_data_o  (data_o),
    .ulpi_data_oe (oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One register operation with the transceiver modelled inline.
  // ab: byte index at which DIR is raised (n = stop cycle of a write), -1 none.
  // rab: 1 = NXT in read data cycle, 2 = DIR falls before read data.
  task automatic run_op(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        input int lat, input int ab, input int rab,
                        input bit tanxt, input bit noise);
    logic [7:0] ex [3];
    logic [7:0] val;
    int n;
    bit ext;
    bit retry;
    int i;
    string tag;
    ext   = (a > 8'h2E);
    ex[0] = {(wr ? 2'b10 : 2'b11), (ext ? 6'h2F : a[5:0])};
    ex[1] = 8'h00;
    ex[2] = 8'h00;
    n = 1;
    if (ext) begin ex[n] = a; n++; end
    if (wr)  begin ex[n] = d; n++; end
    val = phy_regs[a];

    chk(req_ready == 1'b1, "R8 ready while idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = noise;
    if (noise) begin req_write = ~wr; req_addr = ~a; req_wdata = ~d; end
    chk(req_ready == 1'b0, "R8 busy after accept", req_ready, 0);

    retry = 1'b1;
    while (retry) begin
      retry = 1'b0;
      i = 0;
      while (i < n) begin
        if (i == 0)           tag = "R2 R3 R4 command byte";
        else if (ext && i == 1) tag = "R4 extended address byte";
        else                  tag = "R2 write data byte";
        for (int k = 0; k < lat; k++) begin
          chk(oe && data_o == ex[i], tag, data_o, ex[i]);
          @(negedge clk);
        end
        if (ab == i) begin
          dir = 1'b1; #1;
          chk(!oe, "R6 bus released on DIR", oe, 0);
          @(negedge clk);
          chk(!oe && !done, "R6 no drive and no done while aborted", {oe, done}, 0);
          dir = 1'b0; nxt = 1'b1; #1;
          chk(!oe, "R5 no drive in turnaround", oe, 0);
          @(negedge clk);
          nxt = 1'b0;
          chk(oe && data_o == ex[0], "R9 R6 restart at command byte", data_o, ex[0]);
          ab = -1;
          i = 0;
        end else begin
          chk(oe && data_o == ex[i], tag, data_o, ex[i]);
          nxt = 1'b1;
          @(negedge clk);
          nxt = 1'b0;
          i++;
        end
      end

      if (wr) begin
        if (ab == n) begin
          dir = 1'b1; #1;
          chk(!stp && !oe, "R6 stop aborted by DIR", {stp, oe}, 0);
          @(negedge clk);
          chk(!done, "R6 no done on aborted stop", done, 0);
          dir = 1'b0;
          @(negedge clk);
          chk(oe && data_o == ex[0], "R6 retry after stop abort", data_o, ex[0]);
          ab = -1;
          retry = 1'b1;
        end else begin
          chk(stp && oe && data_o == 8'h00, "R2 stop cycle", {stp, oe, data_o}, 10'h300);
          @(negedge clk);
          chk(done && req_ready && !stp, "R2 R8 write done", {done, req_ready, stp}, 3'b110);
          req_valid = 1'b0;
          @(negedge clk);
          chk(!done, "R8 single done pulse", done, 0);
          phy_regs[a] = d;
        end
      end else begin
        chk(!oe, "R3 bus released for read", oe, 0);
        dir = 1'b1; nxt = tanxt; data_i = ~val;
        @(negedge clk);
        nxt = 1'b0;
        chk(!oe && !done, "R3 R9 turnaround not sampled", {oe, done}, 0);
        if (rab == 1) begin
          nxt = 1'b1; data_i = 8'hEE;
          @(negedge clk);
          nxt = 1'b0;
          chk(!oe && !done, "R7 read abandoned on NXT", {oe, done}, 0);
          @(negedge clk);
          dir = 1'b0;
          @(negedge clk);
          chk(oe && data_o == ex[0], "R7 read retried", data_o, ex[0]);
          rab = 0;
          retry = 1'b1;
        end else if (rab == 2) begin
          dir = 1'b0; nxt = 1'b1;
          @(negedge clk);
          nxt = 1'b0;
          chk(oe && data_o == ex[0] && !done, "R7 R9 read retried after DIR fall", data_o, ex[0]);
          rab = 0;
          retry = 1'b1;
        end else begin
          data_i = val;
          @(negedge clk);
          chk(done && rdata == val, "R3 read data captured", rdata, val);
          chk(!req_ready, "R8 busy until DIR falls", req_ready, 0);
          dir = 1'b0; req_valid = 1'b0;
          @(negedge clk);
          chk(!done && req_ready, "R8 single done and idle", {done, req_ready}, 1);
        end
      end
    end
  endtask

  initial begin
    #(10 * 150000);
    n_err++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = 8'h00;
    req_wdata = 8'h00; dir = 1'b0; nxt = 1'b0; data_i = 8'h00;
    for (int j = 0; j < 256; j++) phy_regs[j] = 8'h00;
    repeat (3) @(negedge clk);
    chk(req_ready && !oe && !stp && !done, "R1 state in reset", {req_ready, oe, stp, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !oe && !stp && !done, "R1 idle after reset", {req_ready, oe, stp, done}, 4'b1000);

    for (int a = 0; a < 256; a++) begin
      int nb;
      int abp;
      nb  = 1 + ((a > 8'h2E) ? 1 : 0) + 1;
      abp = (a % 5 == 2) ? ((a / 5) % (nb + 1)) : -1;
      run_op(1'b1, 8'(a), 8'(a * 7 + 3), a % 3, abp, 0, a[1], a[0]);
    end

    for (int a = 0; a < 256; a++) begin
      int nb;
      int abp;
      int rabp;
      nb   = 1 + ((a > 8'h2E) ? 1 : 0);
      abp  = (a % 6 == 4) ? ((a / 6) % nb) : -1;
      rabp = (a % 4 == 1) ? 1 : ((a % 4 == 3) ? 2 : 0);
      run_op(1'b0, 8'(a), 8'h00, (a + 1) % 3, abp, rabp, a[2], a[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule